// File: doc/BRIEF.md
# Vector Element Reissue Sequencer

This block is the arithmetic-instruction holding register and issue control of a floating-point unit whose single register file serves both scalar values and vector elements. The CPU hands over one 32-bit arithmetic instruction through a valid/ready handshake. The block then sends it to the functional-unit issue port one element at a time. After each element it rewrites the held word: the remaining-count field drops by one, the destination specifier moves up by one, and each source specifier moves up only when its stride bit is set. A scalar operation is a vector whose count field is zero.

Each element uses the same issue path as a scalar operation. While an external scoreboard reports that an operand or destination is reserved, the element waits. Elements of one vector may therefore depend on one another, as in a running sum or a recurrence. The functional unit reports an overflow a fixed number of cycles after issue and tags it with the destination register. An overflow on an element of the vector that is still issuing cancels the rest of that vector. For each vector, the destination of the first element that overflows is kept in a status register. An instruction that names the reserved unit code is refused with a one-cycle illegal flag.

Top module: `vec_issue_seq`

## Requirements
- R1: The instruction word is split as follows, MSB first: bits 31:28 major opcode, 27:22 destination Rr, 21:16 source Ra, 15:10 source Rb, 9:8 unit, 7:6 func, 5:2 element count minus one, bit 1 Ra stride, bit 0 Rb stride. Each issued element shows the held unit, func, Rr, Ra and Rb on the issue port.
- R2: A legal instruction whose count field is N issues exactly N+1 elements, one in each unstalled cycle, and then leaves the register empty. A count of 0 issues a single scalar element, and a count of 15 issues sixteen.
- R3: From one element to the next, Rr rises by one. Ra rises by one only when bit 1 is 1, and Rb rises by one only when bit 0 is 1. All three wrap modulo 64.
- R4: While stall is high, no element issues and the held instruction is kept unchanged.
- R5: in_ready is high only when the register is empty, or when the last element issues in that cycle. An accepted legal word can issue its first element in the following cycle at the earliest.
- R6: An accepted word with unit code 0 is not loaded. The illegal output is high in the cycle after acceptance, and nothing issues for it.
- R7: An overflow report is linked to the element issued exactly three cycles earlier. If that element belongs to the vector still in the register, nothing issues in the report cycle, and the register is empty in the next cycle.
- R8: The status register takes the tagged destination of the first reported overflow of each vector. Later reports for the same vector leave it unchanged. A report for an earlier vector updates the status but does not cancel the current vector.
- R9: After reset nothing issues, in_ready is high, and both the status-valid and illegal outputs are low.
- R10: iss_last is high exactly when the element being issued is the final one of its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | CPU offers an instruction |
| in_instr | input | 32 | Instruction word |
| in_ready | output | 1 | Register can take the offered word this cycle |
| stall | input | 1 | Scoreboard holds the current element back |
| iss_valid | output | 1 | An element issues this cycle |
| iss_unit | output | 2 | Functional unit select |
| iss_func | output | 2 | Operation within the unit |
| iss_rr | output | 6 | Destination register of the element |
| iss_ra | output | 6 | First source register |
| iss_rb | output | 6 | Second source register |
| iss_last | output | 1 | Element is the final one of its vector |
| ovf_valid | input | 1 | Functional unit reports an overflow |
| ovf_rr | input | 6 | Destination tag of the overflowing element |
| stat_valid | output | 1 | Status register holds a captured overflow |
| stat_rr | output | 6 | Destination of the captured overflow |
| illegal | output | 1 | Previous cycle accepted a reserved-unit word |

## Verification
The issue port depends combinationally on stall and on the overflow report, so the result of a cycle appears in that same cycle. The first element of a word appears one cycle after the word is accepted. The illegal flag appears one cycle after acceptance, and the status register changes one cycle after a report. The bench drives all inputs just after the falling edge and samples one time unit later. It keeps its own cycle counter and schedules each overflow report for exactly three cycles after the issue it observed. It decides whether a cancel is expected by checking whether the vector is still issuing in that cycle. It reads the status only after every report still in flight is due.

// File: rtl/vis_pkg.sv
package vis_pkg;
  localparam int OPC_W  = 4;
  localparam int REG_W  = 6;
  localparam int UNIT_W = 2;
  localparam int FUNC_W = 2;
  localparam int CNT_W  = 4;
  localparam int INSTR_W = OPC_W + 3 * REG_W + UNIT_W + FUNC_W + CNT_W + 2;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [REG_W-1:0]  rr;
    logic [REG_W-1:0]  ra;
    logic [REG_W-1:0]  rb;
    logic [UNIT_W-1:0] unit;
    logic [FUNC_W-1:0] func;
    logic [CNT_W-1:0]  cnt;
    logic              sra;
    logic              srb;
  } vinstr_t;

  // advance one register specifier by the enable bit, wrapping at the top
  function automatic logic [REG_W-1:0] spec_step(input logic [REG_W-1:0] s,
                                                 input logic en);
    return s + {{(REG_W-1){1'b0}}, en};
  endfunction

  // one fewer element remaining
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic unit_is_legal(input logic [UNIT_W-1:0] u);
    return u != '0;
  endfunction
endpackage

// File: rtl/vis_advance.sv
module vis_advance
  import vis_pkg::*;
(
  input  vinstr_t cur,
  output vinstr_t nxt,
  output logic    last
);
  localparam int NSPEC = 3;

  logic [NSPEC-1:0][REG_W-1:0] spec_in;
  logic [NSPEC-1:0][REG_W-1:0] spec_out;
  logic [NSPEC-1:0]            spec_en;

  // index 2: destination, 1: first source, 0: second source
  assign spec_in = {cur.rr, cur.ra, cur.rb};
  assign spec_en = {1'b1, cur.sra, cur.srb};

  for (genvar g = 0; g < NSPEC; g++) begin : g_inc
    assign spec_out[g] = spec_step(spec_in[g], spec_en[g]);
  end

  always_comb begin
    nxt      = cur;
    nxt.rr   = spec_out[2];
    nxt.ra   = spec_out[1];
    nxt.rb   = spec_out[0];
    nxt.cnt  = cnt_step(cur.cnt);
  end

  assign last = (cur.cnt == '0);
endmodule

// File: rtl/vis_ovf_track.sv
module vis_ovf_track
  import vis_pkg::*;
#(
  parameter int LAT  = 3,
  parameter int ID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [ID_W-1:0]  fire_id,
  input  logic             cur_valid,
  input  logic [ID_W-1:0]  cur_id,
  input  logic             load,
  input  logic [ID_W-1:0]  load_id,
  input  logic             ovf_valid,
  input  logic [REG_W-1:0] ovf_rr,
  output logic             cancel,
  output logic             stat_valid,
  output logic [REG_W-1:0] stat_rr
);
  localparam int NID = 1 << ID_W;

  logic [LAT-1:0]           hist_v;
  logic [LAT-1:0][ID_W-1:0] hist_id;
  logic [NID-1:0]           seen_q;

  logic             tracked;
  logic [ID_W-1:0]  rep_id;
  logic             capture;

  assign rep_id  = hist_id[LAT-1];
  assign tracked = ovf_valid && hist_v[LAT-1];
  assign cancel  = tracked && cur_valid && (rep_id == cur_id);
  assign capture = tracked && !seen_q[rep_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_v     <= '0;
      hist_id    <= '0;
      seen_q     <= '0;
      stat_valid <= 1'b0;
      stat_rr    <= '0;
    end else begin
      hist_v[0]  <= fire;
      hist_id[0] <= fire_id;
      for (int i = 1; i < LAT; i++) begin
        hist_v[i]  <= hist_v[i-1];
        hist_id[i] <= hist_id[i-1];
      end
      if (load) seen_q[load_id] <= 1'b0;
      if (capture) begin
        seen_q[rep_id] <= 1'b1;
        stat_valid     <= 1'b1;
        stat_rr        <= ovf_rr;
      end
    end
  end

  // R7: a cancel only ever targets a vector that is still held
  assert_cancel_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |-> cur_valid);

  // R8: a repeat report for a vector already captured keeps the status
  assert_keep_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tracked && seen_q[rep_id] && !(load && load_id == rep_id)) |=> $stable(stat_rr));

  // R8: first report of a vector is captured one cycle later
  assert_capture_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (stat_valid && stat_rr == $past(ovf_rr)));
endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq
  import vis_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               in_ready,
  input  logic               stall,
  output logic               iss_valid,
  output logic [UNIT_W-1:0]  iss_unit,
  output logic [FUNC_W-1:0]  iss_func,
  output logic [REG_W-1:0]   iss_rr,
  output logic [REG_W-1:0]   iss_ra,
  output logic [REG_W-1:0]   iss_rb,
  output logic               iss_last,
  input  logic               ovf_valid,
  input  logic [REG_W-1:0]   ovf_rr,
  output logic               stat_valid,
  output logic [REG_W-1:0]   stat_rr,
  output logic               illegal
);
  // tag space must exceed the number of vectors that can start in LAT cycles
  localparam int ID_W = $clog2(LAT + 1) + 1;

  vinstr_t         ir_q;
  logic            vld_q;
  logic [ID_W-1:0] id_q;
  logic            illegal_q;

  vinstr_t         in_word;
  vinstr_t         ir_next;
  logic            is_last;
  logic            cancel;
  logic            fire;
  logic            accept;
  logic            load_legal;
  logic [ID_W-1:0] id_next;

  assign in_word    = vinstr_t'(in_instr);
  assign fire       = vld_q && !stall && !cancel;
  assign in_ready   = !vld_q || (fire && is_last);
  assign accept     = in_valid && in_ready;
  assign load_legal = accept && unit_is_legal(in_word.unit);
  assign id_next    = id_q + {{(ID_W-1){1'b0}}, 1'b1};

  vis_advance u_adv (
    .cur  (ir_q),
    .nxt  (ir_next),
    .last (is_last)
  );

  vis_ovf_track #(.LAT(LAT), .ID_W(ID_W)) u_ovf (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .fire_id    (id_q),
    .cur_valid  (vld_q),
    .cur_id     (id_q),
    .load       (load_legal),
    .load_id    (id_next),
    .ovf_valid  (ovf_valid),
    .ovf_rr     (ovf_rr),
    .cancel     (cancel),
    .stat_valid (stat_valid),
    .stat_rr    (stat_rr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q      <= '0;
      vld_q     <= 1'b0;
      id_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && !unit_is_legal(in_word.unit);
      if (load_legal) begin
        ir_q  <= in_word;
        vld_q <= 1'b1;
        id_q  <= id_next;
      end else if (fire) begin
        if (is_last) vld_q <= 1'b0;
        else         ir_q  <= ir_next;
      end else if (cancel) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign iss_valid = fire;
  assign iss_unit  = ir_q.unit;
  assign iss_func  = ir_q.func;
  assign iss_rr    = ir_q.rr;
  assign iss_ra    = ir_q.ra;
  assign iss_rb    = ir_q.rb;
  assign iss_last  = fire && is_last;
  assign illegal   = illegal_q;

  // R4: the scoreboard hold blocks issue and freezes the held word
  assert_no_issue_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !iss_valid);
  assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && vld_q && !cancel) |=> (vld_q && $stable(ir_q)));

  // R5: an accepted legal word is held next cycle exactly as offered
  assert_load_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_legal |=> (vld_q && ir_q == $past(in_word)));

  // R2: the final element empties the register unless a new word arrives
  assert_clear_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_last && !accept) |=> !vld_q);

  // R3: destination advances by one between consecutive elements
  assert_rr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_last) |=> (ir_q.rr == $past(ir_q.rr) + {{(REG_W-1){1'b0}}, 1'b1}));

  // R6: a reserved-unit word raises the flag and leaves nothing to issue
  assert_illegal_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !unit_is_legal(in_word.unit) && !vld_q) |=> (illegal && !vld_q));

  // R7: a cancel empties the register
  assert_cancel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !vld_q);

  // R10: the last marker only accompanies an issued element
  assert_last_with_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    iss_last |-> iss_valid);
endmodule

// File: tb/vec_issue_seq_tb.sv
module vec_issue_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_instr;
  logic        in_ready;
  logic        stall;
  logic        iss_valid;
  logic [1:0]  iss_unit;
  logic [1:0]  iss_func;
  logic [5:0]  iss_rr, iss_ra, iss_rb;
  logic        iss_last;
  logic        ovf_valid;
  logic [5:0]  ovf_rr;
  logic        stat_valid;
  logic [5:0]  stat_rr;
  logic        illegal;

  int n_chk  = 0;
  int n_fail = 0;
  int w      = 0;
  int due_w[2];
  logic [5:0] due_rr[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_issue_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_ready(in_ready), .stall(stall), .iss_valid(iss_valid),
    .iss_unit(iss_unit), .iss_func(iss_func), .iss_rr(iss_rr),
    .iss_ra(iss_ra), .iss_rb(iss_rb), .iss_last(iss_last),
    .ovf_valid(ovf_valid), .ovf_rr(ovf_rr), .stat_valid(stat_valid),
    .stat_rr(stat_rr), .illegal(illegal)
  );

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int rr, input int ra, input int rb,
                                     input int unit, input int func, input int cnt,
                                     input int sra, input int srb);
    return {op[3:0], rr[5:0], ra[5:0], rb[5:0], unit[1:0], func[1:0], cnt[3:0],
            sra[0], srb[0]};
  endfunction

  // specifier of element k: start plus k steps of the stride, modulo 64
  function automatic logic [5:0] elem_spec(input logic [5:0] base, input int k, input int step);
    int v;
    v = (int'(base) + k * step) % 64;
    return v[5:0];
  endfunction

  task automatic tick(input logic st, input logic iv, input logic [31:0] word);
    @(negedge clk);
    w++;
    stall     = st;
    in_valid  = iv;
    in_instr  = word;
    ovf_valid = 1'b0;
    ovf_rr    = '0;
    for (int i = 0; i < 2; i++) begin
      if (due_w[i] == w) begin
        ovf_valid = 1'b1;
        ovf_rr    = due_rr[i];
        due_w[i]  = -1;
      end
    end
    #1;
  endtask

  task automatic run_vec(input logic [31:0] word, input int stall_pct, input int ovf_elem,
                         input bit second, input bit tail);
    logic [5:0] rr0, ra0, rb0;
    int  len, k, cancel_w, guard;
    bit  acc, cancelled;
    logic [5:0] first_rr;
    logic st;
    rr0 = word[27:22]; ra0 = word[21:16]; rb0 = word[15:10];
    len = int'(word[5:2]) + 1;
    cancel_w = -1; first_rr = '0;
    acc = 0; guard = 0;
    while (!acc && guard < 50) begin
      tick(1'b0, 1'b1, word);
      acc = in_ready;
      guard++;
    end
    chk(acc, "R5 word accepted when register empty", int'(acc), 1);
    if (word[9:8] == 2'd0) begin
      tick(1'b0, 1'b0, '0);
      chk(illegal === 1'b1, "R6 illegal flag after reserved unit", int'(illegal), 1);
      for (int i = 0; i < 3; i++) begin
        chk(iss_valid === 1'b0, "R6 nothing issued for reserved unit", int'(iss_valid), 0);
        chk(in_ready === 1'b1, "R6 register stays empty", int'(in_ready), 1);
        tick(1'b0, 1'b0, '0);
      end
      return;
    end
    k = 0; cancelled = 0; guard = 0;
    while (k < len && !cancelled && guard < 400) begin
      guard++;
      st = (($urandom % 100) < stall_pct);
      tick(st, 1'b0, '0);
      if (cancel_w == w) begin
        chk(iss_valid === 1'b0, "R7 no issue in cancel cycle", int'(iss_valid), 0);
        cancelled = 1;
      end else if (st) begin
        chk(iss_valid === 1'b0, "R4 no issue while stalled", int'(iss_valid), 0);
        chk(in_ready === 1'b0, "R4 busy register not ready while stalled", int'(in_ready), 0);
      end else begin
        chk(iss_valid === 1'b1, "R2 element issues in unstalled cycle", int'(iss_valid), 1);
        if (iss_valid === 1'b1) begin
          chk(iss_rr == elem_spec(rr0, k, 1), "R3 destination step", int'(iss_rr),
              int'(elem_spec(rr0, k, 1)));
          chk(iss_ra == elem_spec(ra0, k, int'(word[1])), "R3 Ra stride", int'(iss_ra),
              int'(elem_spec(ra0, k, int'(word[1]))));
          chk(iss_rb == elem_spec(rb0, k, int'(word[0])), "R3 Rb stride", int'(iss_rb),
              int'(elem_spec(rb0, k, int'(word[0]))));
          chk(iss_unit == word[9:8] && iss_func == word[7:6], "R1 unit and func fields",
              int'({iss_unit, iss_func}), int'(word[9:6]));
          chk(iss_last === (k == len - 1), "R10 last marker", int'(iss_last),
              int'(k == len - 1));
          chk(in_ready === (k == len - 1), "R5 ready only on last element", int'(in_ready),
              int'(k == len - 1));
          if (k == ovf_elem) begin
            due_w[0] = w + 3; due_rr[0] = iss_rr;
            cancel_w = w + 3; first_rr = iss_rr;
          end
          if (second && ovf_elem >= 0 && k == ovf_elem + 1) begin
            due_w[1] = w + 3; due_rr[1] = iss_rr;
          end
          k++;
        end
      end
    end
    tick(1'b0, 1'b0, '0);
    chk(iss_valid === 1'b0, "R2 register empty after vector", int'(iss_valid), 0);
    chk(in_ready === 1'b1, "R7 ready after end or cancel", int'(in_ready), 1);
    if (!cancelled)
      chk(k == len, "R2 element count", k, len);
    if (ovf_elem >= 0 && tail) begin
      for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, '0);
      chk(stat_valid === 1'b1 && stat_rr == first_rr, "R8 first overflow captured",
          int'(stat_rr), int'(first_rr));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    logic [31:0] word;
    int len, oe;
    void'($urandom(32'h1c0ffee));
    due_w[0] = -1; due_w[1] = -1;
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; stall = 1'b0;
    ovf_valid = 1'b0; ovf_rr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk(iss_valid === 1'b0, "R9 no issue after reset", int'(iss_valid), 0);
    chk(in_ready === 1'b1, "R9 ready after reset", int'(in_ready), 1);
    chk(stat_valid === 1'b0, "R9 status clear after reset", int'(stat_valid), 0);
    chk(illegal === 1'b0, "R9 illegal low after reset", int'(illegal), 0);

    // R2 scalar: count field 0
    run_vec(mk(6, 5, 7, 9, 1, 2, 0, 1, 1), 0, -1, 0, 1);
    // R3 wrap with sixteen elements, both strides set
    run_vec(mk(6, 62, 60, 55, 2, 0, 15, 1, 1), 0, -1, 0, 1);
    // vector := scalar op scalar
    run_vec(mk(6, 20, 3, 4, 1, 1, 3, 0, 0), 0, -1, 0, 1);
    // R4 mixed stride under heavy stall
    run_vec(mk(6, 30, 10, 40, 3, 0, 4, 1, 0), 50, -1, 0, 1);
    // R6 reserved unit
    run_vec(mk(6, 1, 2, 3, 0, 0, 7, 1, 1), 0, -1, 0, 1);
    // R7/R8 overflow on element 2 with a second report in flight
    run_vec(mk(6, 8, 0, 16, 2, 0, 7, 1, 1), 0, 2, 1, 1);
    // R8 report for an earlier scalar must not cancel the next vector
    run_vec(mk(6, 10, 11, 12, 1, 0, 0, 0, 0), 0, 0, 0, 0);
    run_vec(mk(6, 40, 0, 1, 1, 0, 7, 1, 0), 0, -1, 0, 1);
    chk(stat_valid === 1'b1 && stat_rr == 6'd10, "R8 earlier vector report captured",
        int'(stat_rr), 10);

    for (int n = 0; n < 60; n++) begin
      word = $urandom;
      word[9:8] = 2'(1 + ($urandom % 3));
      len = int'(word[5:2]) + 1;
      oe = (($urandom % 4) == 0) ? int'($urandom % len) : -1;
      run_vec(word, 30, oe, ($urandom % 2) == 1, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule